// File: doc/BRIEF.md
# Retired-Instruction Counter with Early Read Forwarding

This block keeps the 64-bit machine-level count of retired instructions for a short in-order pipeline. The CSR access stage sits one stage ahead of writeback (WB). A read issued while an older counting instruction is in WB, but not yet added to the register, gets the register value plus one. That way every read returns the count as it stands just before the reading instruction retires. A registered flag records whether the last instruction handed to WB counts toward the total. Forwarding is allowed only while WB is actually occupied, so a stale flag left behind by a drained WB can never inflate a read.

Explicit CSR writes replace the counter as soon as the writing instruction leaves the access stage. A two-state controller then swallows that instruction's own retirement increment. In `ST_RUN` (normal counting) a retirement of a counting instruction adds one in the following cycle. A CSR write to either counter half takes `ST_RUN -> ST_SKIP`. In `ST_SKIP` (writer still to retire) forwarding and incrementing are both off. The next retire pulse takes `ST_SKIP -> ST_RUN`, unless another counter write arrives in the same cycle, which keeps `ST_SKIP`. The caller guarantees that an instruction goes to WB the cycle after it leaves the access stage and retires there without stalling, and that a CSR request is only raised together with `id_adv_i`.

Top module: `retire_count_csr`

## Requirements
- R1: After reset the counter is zero, so both halves read 0.
- R2: The low 32 bits are read and written at address 0xB02 and the high 32 bits at 0xB82. A request to any other address returns 0 and a write there changes nothing.
- R3: A read made while WB is empty (`wb_valid_i` low) returns the raw register half.
- R4: A read made while WB holds a counting, non-writer instruction returns the register plus one.
- R5: A non-counting instruction (handed over with `id_counts_i` low) is neither forwarded nor counted.
- R6: A retire pulse of a counting instruction raises the register by exactly one in the next cycle, and the register never changes otherwise except by a write.
- R7: With the counter at 0x3C after several empty-WB cycles, two back-to-back counting reads return 0x3C then 0x3D, and a read after one more idle cycle returns 0x3E.
- R8: A write takes effect in the next cycle, the writing instruction's own retirement adds nothing, and the instruction right after the writer reads exactly the written value.
- R9: A write to one half leaves the other half as the forwarded value, so an older instruction retiring in the same cycle is still counted.
- R10: The plus-one forward carries across bit 31, so a high-half read during the retire cycle sees the carry.
- R11: Under random bubbles, counting flags, reads and writes, every read matches an architectural count of retired instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| retire_i | input | 1 | The instruction in WB retires this cycle |
| wb_valid_i | input | 1 | WB holds an instruction this cycle |
| id_adv_i | input | 1 | An instruction leaves the access stage toward WB this cycle |
| id_counts_i | input | 1 | That instruction counts toward the retired total |
| csr_req_i | input | 1 | CSR access by the advancing instruction |
| csr_we_i | input | 1 | The access also writes |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data, combinational in the request cycle |

## Verification
Read data is combinational, so it is due in the same cycle as the request. The bench samples it mid-cycle, after driving on the falling edge. The effects of a write and of a retirement appear one clock later, and the bench observes them only through a subsequent read. Its reference count is updated in program order as each instruction is issued, which matches what the one-cycle register lag plus forwarding must produce. The scoreboard queue pairs each request with the value computed at issue, and the monitor pops that entry in the same cycle.

// File: rtl/rc_pkg.sv
package rc_pkg;
    localparam int unsigned RC_HALF_W = 32;
    localparam int unsigned RC_ADDR_W = 12;
    localparam logic [RC_ADDR_W-1:0] RC_LO_ADDR = 12'hB02;
    localparam logic [RC_ADDR_W-1:0] RC_HI_ADDR = 12'hB82;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_SKIP = 1'b1
    } rc_state_e;
endpackage

// File: rtl/rc_fsm.sv
module rc_fsm
    import rc_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      wr_hit_i,
    input  logic      retire_i,
    output rc_state_e state_o,
    output logic      run_o
);
    rc_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_RUN;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (wr_hit_i) state_d = ST_SKIP;
            ST_SKIP: begin
                if (wr_hit_i)      state_d = ST_SKIP;
                else if (retire_i) state_d = ST_RUN;
            end
        endcase
    end

    always_comb begin
        state_o = state_q;
        run_o   = (state_q == ST_RUN);
    end
endmodule

// File: rtl/rc_counter.sv
module rc_counter #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             id_adv_i,
    input  logic             id_counts_i,
    input  logic             wb_valid_i,
    input  logic             retire_i,
    input  logic             run_i,
    input  logic             wr_hit_i,
    input  logic [CNT_W-1:0] wr_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] fwd_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             flag_q;
    logic [CNT_W-1:0] cnt_q;
    logic             spec, inc;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       flag_q <= 1'b0;
        else if (id_adv_i) flag_q <= id_counts_i;
    end

    always_comb begin
        spec  = flag_q & wb_valid_i & run_i;
        inc   = flag_q & retire_i & run_i;
        fwd_o = spec ? cnt_q + ONE : cnt_q;
        cnt_o = cnt_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       cnt_q <= '0;
        else if (wr_hit_i) cnt_q <= wr_val_i;
        else if (inc)      cnt_q <= cnt_q + ONE;
    end
endmodule

// File: rtl/rc_access.sv
module rc_access #(
    parameter int unsigned HALF_W  = 32,
    parameter int unsigned ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] LO_ADDR = 12'hB02,
    parameter logic [ADDR_W-1:0] HI_ADDR = 12'hB82
) (
    input  logic                csr_req_i,
    input  logic                csr_we_i,
    input  logic [ADDR_W-1:0]   csr_addr_i,
    input  logic [HALF_W-1:0]   csr_wdata_i,
    input  logic [2*HALF_W-1:0] fwd_i,
    output logic [HALF_W-1:0]   rdata_o,
    output logic                wr_hit_o,
    output logic [2*HALF_W-1:0] wr_val_o
);
    localparam int unsigned NHALF = 2;

    logic [NHALF-1:0]  hit;
    logic [HALF_W-1:0] part [NHALF];

    for (genvar g = 0; g < NHALF; g++) begin : g_half
        localparam logic [ADDR_W-1:0] A = (g == 0) ? LO_ADDR : HI_ADDR;
        assign hit[g] = csr_req_i && (csr_addr_i == A);
        assign part[g] = hit[g] ? fwd_i[g*HALF_W +: HALF_W] : '0;
        assign wr_val_o[g*HALF_W +: HALF_W] =
            (csr_we_i && hit[g]) ? csr_wdata_i : fwd_i[g*HALF_W +: HALF_W];
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NHALF; i++) rdata_o = rdata_o | part[i];
        wr_hit_o = csr_we_i && (|hit);
    end
endmodule

// File: rtl/retire_count_csr.sv
module retire_count_csr
    import rc_pkg::*;
#(
    parameter int unsigned HALF_W  = RC_HALF_W,
    parameter int unsigned ADDR_W  = RC_ADDR_W,
    parameter logic [ADDR_W-1:0] LO_ADDR = RC_LO_ADDR,
    parameter logic [ADDR_W-1:0] HI_ADDR = RC_HI_ADDR
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              retire_i,
    input  logic              wb_valid_i,
    input  logic              id_adv_i,
    input  logic              id_counts_i,
    input  logic              csr_req_i,
    input  logic              csr_we_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [HALF_W-1:0] csr_wdata_i,
    output logic [HALF_W-1:0] csr_rdata_o
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    rc_state_e        state_q;
    logic             run;
    logic             wr_hit;
    logic [CNT_W-1:0] wr_val;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] fwd;

    rc_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_hit_i (wr_hit),
        .retire_i (retire_i),
        .state_o  (state_q),
        .run_o    (run)
    );

    rc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .id_adv_i    (id_adv_i),
        .id_counts_i (id_counts_i),
        .wb_valid_i  (wb_valid_i),
        .retire_i    (retire_i),
        .run_i       (run),
        .wr_hit_i    (wr_hit),
        .wr_val_i    (wr_val),
        .cnt_o       (cnt_q),
        .fwd_o       (fwd)
    );

    rc_access #(
        .HALF_W  (HALF_W),
        .ADDR_W  (ADDR_W),
        .LO_ADDR (LO_ADDR),
        .HI_ADDR (HI_ADDR)
    ) u_acc (
        .csr_req_i   (csr_req_i),
        .csr_we_i    (csr_we_i),
        .csr_addr_i  (csr_addr_i),
        .csr_wdata_i (csr_wdata_i),
        .fwd_i       (fwd),
        .rdata_o     (csr_rdata_o),
        .wr_hit_o    (wr_hit),
        .wr_val_o    (wr_val)
    );
endmodule

// File: rtl/rc_chk.sv
module rc_chk
    import rc_pkg::*;
#(
    parameter int unsigned HALF_W  = RC_HALF_W,
    parameter int unsigned ADDR_W  = RC_ADDR_W,
    parameter logic [ADDR_W-1:0] LO_ADDR = RC_LO_ADDR,
    parameter logic [ADDR_W-1:0] HI_ADDR = RC_HI_ADDR
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                retire_i,
    input logic                wb_valid_i,
    input logic                csr_req_i,
    input logic                csr_we_i,
    input logic [ADDR_W-1:0]   csr_addr_i,
    input logic [HALF_W-1:0]   csr_wdata_i,
    input logic [HALF_W-1:0]   csr_rdata_o,
    input logic [2*HALF_W-1:0] cnt_q,
    input rc_state_e           state_q,
    input logic                wr_hit
);
    localparam logic [2*HALF_W-1:0] ONE_W = {{(2*HALF_W-1){1'b0}}, 1'b1};
    localparam logic [HALF_W-1:0]   ONE_H = {{(HALF_W-1){1'b0}}, 1'b1};

    logic rd_lo;
    assign rd_lo = csr_req_i && (csr_addr_i == LO_ADDR);

    AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_i && csr_addr_i != LO_ADDR && csr_addr_i != HI_ADDR) |-> csr_rdata_o == '0); // R2
    AST_EMPTY_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_lo && !wb_valid_i) |-> csr_rdata_o == cnt_q[HALF_W-1:0]); // R3
    AST_FWD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_lo |-> (csr_rdata_o == cnt_q[HALF_W-1:0] || csr_rdata_o == cnt_q[HALF_W-1:0] + ONE_H)); // R4
    AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(wr_hit) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE_W)); // R6
    AST_WRITE_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_lo && csr_we_i) |=> cnt_q[HALF_W-1:0] == $past(csr_wdata_i)); // R8
    AST_SKIP_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_lo && state_q == ST_SKIP) |-> csr_rdata_o == cnt_q[HALF_W-1:0]); // R8
    AST_SKIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SKIP && retire_i && !wr_hit) |=> cnt_q == $past(cnt_q)); // R8
    AST_HI_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_lo && csr_we_i) |=> (cnt_q[2*HALF_W-1:HALF_W] == $past(cnt_q[2*HALF_W-1:HALF_W]) ||
                                 cnt_q[2*HALF_W-1:HALF_W] == $past(cnt_q[2*HALF_W-1:HALF_W]) + ONE_H)); // R9
endmodule

bind retire_count_csr rc_chk #(
    .HALF_W  (HALF_W),
    .ADDR_W  (ADDR_W),
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .retire_i    (retire_i),
    .wb_valid_i  (wb_valid_i),
    .csr_req_i   (csr_req_i),
    .csr_we_i    (csr_we_i),
    .csr_addr_i  (csr_addr_i),
    .csr_wdata_i (csr_wdata_i),
    .csr_rdata_o (csr_rdata_o),
    .cnt_q       (cnt_q),
    .state_q     (state_q),
    .wr_hit      (wr_hit)
);

// File: tb/sim_retire_count_csr.sv
module sim_retire_count_csr;
    localparam logic [11:0] A_LO = 12'hB02;
    localparam logic [11:0] A_HI = 12'hB82;
    localparam logic [11:0] A_NO = 12'hB00;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        retire_i = 1'b0, wb_valid_i = 1'b0;
    logic        id_adv_i = 1'b0, id_counts_i = 1'b0;
    logic        csr_req_i = 1'b0, csr_we_i = 1'b0;
    logic [11:0] csr_addr_i = '0;
    logic [31:0] csr_wdata_i = '0;
    logic [31:0] csr_rdata_o;

    int          errors = 0;
    int          checks = 0;
    logic [63:0] ref_cnt = '0;
    logic        prev_adv = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    retire_count_csr u0 (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .retire_i    (retire_i),
        .wb_valid_i  (wb_valid_i),
        .id_adv_i    (id_adv_i),
        .id_counts_i (id_counts_i),
        .csr_req_i   (csr_req_i),
        .csr_we_i    (csr_we_i),
        .csr_addr_i  (csr_addr_i),
        .csr_wdata_i (csr_wdata_i),
        .csr_rdata_o (csr_rdata_o)
    );

    // driver: one call = one cycle; pushes the expected read value
    task automatic step(input logic adv, input logic cnt, input logic req, input logic we,
                        input logic [11:0] addr, input logic [31:0] wd, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        wb_valid_i  = prev_adv;
        retire_i    = prev_adv;
        prev_adv    = adv;
        id_adv_i    = adv;
        id_counts_i = cnt;
        csr_req_i   = req & adv;
        csr_we_i    = we;
        csr_addr_i  = addr;
        csr_wdata_i = wd;
        if (req && adv) begin
            exp = (addr == A_LO) ? ref_cnt[31:0] : (addr == A_HI) ? ref_cnt[63:32] : 32'h0;
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        if (adv) begin
            if (req && we && addr == A_LO)      ref_cnt[31:0]  = wd;
            else if (req && we && addr == A_HI) ref_cnt[63:32] = wd;
            else if (cnt)                       ref_cnt        = ref_cnt + 64'd1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, A_NO, 32'h0, "");
    endtask

    // monitor: samples mid-cycle after the driver has settled the inputs
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (rst_ni && csr_req_i) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (csr_rdata_o !== e) begin
                    errors++;
                    $display("FAIL %s: read addr %h got %h expected %h", t, csr_addr_i, csr_rdata_o, e);
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        // R1 reset state
        step(1, 0, 1, 0, A_LO, 0, "R1 low");
        step(1, 0, 1, 0, A_HI, 0, "R1 high");
        // R2 unmapped read and write
        step(1, 0, 1, 0, A_NO, 0, "R2 unmapped read");
        step(1, 0, 1, 1, A_NO, 32'h1234, "R2 unmapped write");
        idle(1);
        step(1, 0, 1, 0, A_LO, 0, "R2 unmapped write ignored");
        // R7 stale-flag scenario, also R3/R4
        step(1, 1, 1, 1, A_LO, 32'h3C, "R8 write old");
        idle(4);
        step(1, 1, 1, 0, A_LO, 0, "R3 R7 first read");
        step(1, 1, 1, 0, A_LO, 0, "R4 R7 second read");
        idle(1);
        step(1, 1, 1, 0, A_LO, 0, "R7 after idle");
        // R5 non-counting instruction
        idle(1);
        step(1, 0, 0, 0, A_NO, 0, "");
        step(1, 0, 1, 0, A_LO, 0, "R5 no forward");
        idle(1);
        step(1, 0, 1, 0, A_LO, 0, "R5 no increment");
        // R6 increment lands a cycle later
        step(1, 1, 0, 0, A_NO, 0, "");
        idle(1);
        step(1, 0, 1, 0, A_LO, 0, "R6 counted");
        // R8 writer skip and next-read exact
        step(1, 1, 1, 1, A_LO, 32'h100, "R8 write");
        step(1, 1, 1, 0, A_LO, 0, "R8 next reads written");
        step(1, 1, 1, 0, A_LO, 0, "R8 writer not counted");
        // R9 write high while older instruction retires
        step(1, 1, 0, 0, A_NO, 0, "");
        step(1, 1, 1, 1, A_HI, 32'h5, "R9 write high");
        idle(1);
        step(1, 0, 1, 0, A_LO, 0, "R9 low keeps older retire");
        step(1, 0, 1, 0, A_HI, 0, "R9 high written");
        // R10 carry across the halves
        step(1, 0, 1, 1, A_LO, 32'hFFFF_FFFF, "R10 write low");
        step(1, 0, 1, 1, A_HI, 32'h7, "R10 write high");
        step(1, 1, 0, 0, A_NO, 0, "");
        step(1, 0, 1, 0, A_HI, 0, "R10 high sees carry");
        step(1, 0, 1, 0, A_LO, 0, "R10 low wrapped");
        // R11 random stream
        for (int i = 0; i < 3000; i++) begin
            logic adv, cnt, req, we;
            logic [11:0] a;
            int sel;
            adv = ($urandom % 3) != 0;
            cnt = ($urandom % 4) != 0;
            req = ($urandom % 2) != 0;
            we  = ($urandom % 8) == 0;
            sel = $urandom % 5;
            a   = (sel < 2) ? A_LO : (sel < 4) ? A_HI : A_NO;
            step(adv, cnt, req, we, a, $urandom, "R11 random");
        end
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11: %0d reads unchecked, expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule